// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that lets a system controller read and change a small bank of 8-bit configuration registers. Each register bit drives a control such as the enable of an individual clock output buffer. The register contents are always visible on a parallel output bus, so downstream logic sees a new value as soon as its byte has been accepted. Every register takes its default value at reset, so the system works even if the controller never touches the bus.

SCL and SDA are oversampled with a fast local clock. SDA is never driven high: the slave only asserts an open-drain pull-down enable. After the address byte, a command byte chooses between a single indexed register access and a sequential block access that carries a byte count. Reads are done by sending the command, then a repeated start and the read address.

There is no valid/ready stream at the edge of this block. The controller sets the pace of every bit on SCL, and the slave never stretches the clock. Back-pressure exists only as a NACK on a byte the slave refuses.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal the configured 7-bit address (default 7'h69, that is D2h to write and D3h to read). It does not acknowledge any other address.
- R2: In the command byte, bit 7 = 1 selects a single-register access and bit 7 = 0 selects a block access. Bits 6:5 must be 00; otherwise the command is not acknowledged and no register changes until the next start.
- R3: A single-register write uses command bit 7 = 1 with the register index in bits 4:0. It writes the next data byte into that register and acknowledges it. An index at or beyond the bank size gets a NACK for its data byte, and no register changes.
- R4: A single-register read (command, repeated start, read address) returns the indexed register MSB first. An index beyond the bank returns FFh.
- R5: A block write (command 00h) takes a byte count, then stores the data bytes into registers 0, 1, 2 and so on in ascending order. Data bytes beyond the count or beyond the bank get a NACK and are discarded.
- R6: A block read first returns the bank size as the byte count, then registers from index 0 upward. It returns to idle once the controller NACKs a byte.
- R7: A stop after any complete byte ends the transfer, and every register already written keeps its new value.
- R8: At reset, register i holds byte i of DEFAULTS (default 80h+i). Byte i of cfg_q is bits 8i+7:8i, and sda_oe is 0.
- R9: A start or stop at any point restarts bit and byte framing. The slave never asserts sda_oe while SCL is high, and it releases SDA after a stop.
- R10: A read address that is not preceded by an accepted command in the same transaction (since the last stop) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_q | output | 8*NREG | All register contents; register i at bits 8i+7:8i |

## Verification
On every cycle the assertions check the bus-level timing rules: sda_oe rises only while SCL is low, SDA is released after a stop and while the slave is idle, a rejected chip-select command never draws an acknowledge, register writes stay inside the bank, and the parallel outputs stay steady unless a write is accepted. Only the directed scenarios can show the transaction-level meaning. That covers which addresses and commands are acknowledged, the byte values that come back on reads (including FFh and the count byte), the ascending order of block transfers, the discarding of excess bytes, and the values that remain after early stops and mid-byte restarts.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_TX
  } smb_phase_e;

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam int         PTR_W         = 6;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o     = scl_pipe[STAGES-1];
  assign sda_o     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_o & ~scl_prev;
  assign scl_fall  = ~scl_o & scl_prev;
  // SDA moving while SCL stays high marks a frame boundary
  assign start_det = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_det  = scl_o & scl_prev & ~sda_prev & sda_o;

  assert_start_stop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
  parameter int                NREG     = 8,
  parameter int                PW       = 6,
  parameter logic [8*NREG-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [8*NREG-1:0] cfg_q
);
  localparam logic [PW-1:0] LIMIT = PW'(NREG);

  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= DEFAULTS[8*g +: 8];
      else if (wr_en && wr_idx == PW'(g))
        regs[g] <= wr_data;
    end
    assign cfg_q[8*g +: 8] = regs[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == PW'(i)) rd_data = regs[i];
  end

  assert_wr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < LIMIT));
  assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int                NREG     = 8,
  parameter logic [6:0]        ADDR7    = 7'h69,
  parameter logic [8*NREG-1:0] DEFAULTS = 64'h8786_8584_8382_8180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [8*NREG-1:0] cfg_q
);
  localparam int            PW    = PTR_W;
  localparam logic [PW-1:0] LIMIT = PW'(NREG);
  localparam logic [7:0]    COUNT = 8'(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_phase_e    phase;
  logic [3:0]    bitcnt;
  logic          in_ack;
  logic [7:0]    sh_in, tx_sh, remain;
  logic [4:0]    offset;
  logic [PW-1:0] ptr;
  logic          have_cmd, blk_mode, tx_active, tx_cnt_pending, mst_nack;
  logic          oe_q;

  logic [7:0]    rd_data, tx_next;
  logic [2:0]    tx_idx;
  logic          byte_end, wr_ok, wr_fire;

  assign byte_end = scl_fall && !in_ack && (bitcnt == BITS_PER_BYTE);
  assign wr_ok    = (remain != 8'd0) && (ptr < LIMIT);
  assign wr_fire  = !start_det && !stop_det && byte_end && (phase == PH_WDATA) && wr_ok;
  assign tx_next  = tx_cnt_pending ? COUNT : rd_data;
  assign tx_idx   = 3'(4'd7 - bitcnt);

  smb_cfg_bank #(.NREG(NREG), .PW(PW), .DEFAULTS(DEFAULTS)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_idx(ptr), .wr_data(sh_in),
    .rd_idx(ptr), .rd_data(rd_data), .cfg_q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; sh_in <= '0; tx_sh <= '0;
      remain <= '0; offset <= '0; ptr <= '0; have_cmd <= 1'b0; blk_mode <= 1'b0;
      tx_active <= 1'b0; tx_cnt_pending <= 1'b0; mst_nack <= 1'b0; oe_q <= 1'b0;
    end else if (start_det) begin
      phase <= PH_ADDR; bitcnt <= '0; in_ack <= 1'b0; oe_q <= 1'b0; tx_active <= 1'b0;
    end else if (stop_det) begin
      phase <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; oe_q <= 1'b0;
      tx_active <= 1'b0; have_cmd <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (bitcnt != BITS_PER_BYTE) begin
          sh_in  <= {sh_in[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (in_ack && phase == PH_TX) begin
          mst_nack <= sda_s;
        end
      end
      if (scl_fall) begin
        if (in_ack) begin
          // end of acknowledge slot
          in_ack <= 1'b0;
          bitcnt <= '0;
          oe_q   <= 1'b0;
          if (phase == PH_TX) begin
            if (tx_active && mst_nack) begin
              phase <= PH_IDLE;
            end else begin
              tx_sh          <= tx_next;
              oe_q           <= ~tx_next[7];
              tx_active      <= 1'b1;
              tx_cnt_pending <= 1'b0;
              if (!tx_cnt_pending) ptr <= ptr + PW'(1);
            end
          end
        end else if (bitcnt == BITS_PER_BYTE) begin
          // a full byte has passed; decide on the acknowledge
          in_ack <= 1'b1;
          oe_q   <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (sh_in[7:1] == ADDR7 && (!sh_in[0] || have_cmd)) begin
                oe_q <= 1'b1;
                if (sh_in[0]) begin
                  phase          <= PH_TX;
                  ptr            <= {1'b0, offset};
                  tx_cnt_pending <= blk_mode;
                  tx_active      <= 1'b0;
                  mst_nack       <= 1'b0;
                end else begin
                  phase <= PH_CMD;
                end
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_CMD: begin
              if (sh_in[6:5] == 2'b00) begin
                oe_q     <= 1'b1;
                have_cmd <= 1'b1;
                blk_mode <= ~sh_in[7];
                offset   <= sh_in[7] ? sh_in[4:0] : 5'd0;
                ptr      <= sh_in[7] ? {1'b0, sh_in[4:0]} : '0;
                remain   <= sh_in[7] ? 8'd1 : 8'd0;
                phase    <= sh_in[7] ? PH_WDATA : PH_COUNT;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_COUNT: begin
              oe_q   <= 1'b1;
              remain <= sh_in;
              phase  <= PH_WDATA;
            end
            PH_WDATA: begin
              if (wr_ok) begin
                oe_q   <= 1'b1;
                ptr    <= ptr + PW'(1);
                remain <= remain - 8'd1;
              end
            end
            default: ;
          endcase
        end else if (phase == PH_TX && tx_active) begin
          oe_q <= ~tx_sh[tx_idx];
        end
      end
    end
  end

  assign sda_oe = oe_q;

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_cs_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_det && !stop_det && byte_end && phase == PH_CMD && sh_in[6:5] != 2'b00)
      |=> (!sda_oe && phase == PH_IDLE));
  assert_read_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TX) |-> have_cmd);
endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int NREG = 8;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [8*NREG-1:0] cfg_q;
  logic sda_line;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] exp_r [NREG];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smb_cfg_slave i_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask
  task automatic hq(); repeat (3) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0;
  endtask
  task automatic bus_rstart();
    hq(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0;
  endtask
  task automatic bus_stop();
    hq(); sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hq(); sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    hq(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); ack = ~sda_line; scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hq(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); b[i] = sda_line; scl_m = 1'b0;
    end
    hq(); sda_m = ~ack_it; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hq(); sda_m = 1'b1;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(cfg_q[8*i +: 8] == exp_r[i], tag, cfg_q[8*i +: 8], exp_r[i]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h80 + 8'(i);
    check_bank("R8 reset default");
    chk(sda_oe == 1'b0, "R8 sda_oe at reset", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'h83, a); chk(a, "R3 command ack", a, 1);
    send_byte(8'h5A, a); chk(a, "R3 data ack", a, 1);
    bus_stop();
    exp_r[3] = 8'h5A;
    check_bank("R3 byte write");
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h81, a);
    send_byte(8'h11, a);
    bus_stop();
    check_bank("R1 foreign address no change");
  endtask

  task automatic t_chip_select();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'hA3, a); chk(!a, "R2 chip select nack", a, 0);
    send_byte(8'h44, a); chk(!a, "R2 data after reject nack", a, 0);
    bus_stop();
    check_bank("R2 no change");
  endtask

  task automatic t_offset_range();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h8A, a);
    send_byte(8'h99, a); chk(!a, "R3 out of range data nack", a, 0);
    bus_stop();
    check_bank("R3 out of range no change");
  endtask

  task automatic t_byte_read(input logic [4:0] off, input logic [7:0] expv);
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a);
    send_byte({3'b100, off}, a);
    bus_rstart();
    send_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b0, b);  chk(b == expv, "R4 byte read value", b, expv);
    bus_stop();
    chk(sda_oe == 1'b0, "R6 idle after nack", sda_oe, 0);
  endtask

  task automatic t_block_write();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a); chk(a, "R5 block command ack", a, 1);
    send_byte(8'h03, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a, "R5 last counted byte ack", a, 1);
    send_byte(8'h44, a); chk(!a, "R5 byte beyond count nack", a, 0);
    bus_stop();
    exp_r[0] = 8'h11; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
    check_bank("R5 block write ascending");
  endtask

  task automatic t_block_overrun();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd20, a);
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'hC0 + 8'(i), a);
      exp_r[i] = 8'hC0 + 8'(i);
    end
    chk(a, "R5 last in-bank byte ack", a, 1);
    send_byte(8'hEE, a); chk(!a, "R5 byte beyond bank nack", a, 0);
    bus_stop();
    check_bank("R5 overrun discarded");
  endtask

  task automatic t_partial_stop();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd4, a);
    send_byte(8'h01, a); send_byte(8'h02, a);
    bus_stop();
    exp_r[0] = 8'h01; exp_r[1] = 8'h02;
    check_bank("R7 early stop keeps bytes");
  endtask

  task automatic t_block_read();
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_rstart();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b); chk(b == 8'(NREG), "R6 block count byte", b, NREG);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, b);
      chk(b == exp_r[i], "R6 block read data", b, exp_r[i]);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R6 released after final nack", sda_oe, 0);
  endtask

  task automatic t_read_no_cmd();
    logic a;
    bus_start();
    send_byte(8'hD3, a); chk(!a, "R10 read without command nack", a, 0);
    bus_stop();
  endtask

  task automatic t_mid_restart();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_bits(8'h85, 4);
    bus_rstart();
    send_byte(8'hD2, a); chk(a, "R9 address after restart ack", a, 1);
    send_byte(8'h80, a);
    send_byte(8'h77, a);
    bus_stop();
    exp_r[0] = 8'h77;
    check_bank("R9 framing restarted");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_wrong_addr();
    t_chip_select();
    t_offset_range();
    t_byte_read(5'd3, 8'h5A);
    t_byte_read(5'd12, 8'hFF);
    t_block_write();
    t_block_overrun();
    t_partial_stop();
    t_block_read();
    t_read_no_cmd();
    t_mid_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule